// File: doc/BRIEF.md
# Multi-Channel Periodic Interrupt Timer

This block produces periodic time-out events on up to eight independent channels. Two shared 8-bit prescaler counters, called base timers here, count down the system clock. Each base timer emits a one-cycle tick when it wraps. Every channel owns a 16-bit down-counter. The counter steps on the ticks of the base timer the channel selects. When a channel counter wraps, it raises a sticky time-out flag and reloads from the channel's own load value. A channel's interrupt line is its flag gated by its interrupt-enable bit.

Software reaches the block through a byte-wide register bus, with a single-cycle write strobe and a combinational read path. The control byte holds the global enable, a stop-on-wait control, a stall-on-freeze control and two write-one force-load bits, one per base timer. A second byte lets software restart any channel counter at once. Two plain inputs, `wait_i` and `freeze_i`, signal the low-power wait state and a debug halt. The controls decide whether either input freezes counting.

Top module: `ptimer_top`

Register map (byte offsets):

| Offset | Name | Meaning |
|---|---|---|
| 0x00 | CTRL | [7] run enable, [6] stop when `wait_i`, [5] stall when `freeze_i`, [4:2] reserved (read 0), [1:0] force-load base timer 1/0 (write 1, read 0) |
| 0x01 | CHRST | bit i = 1 restarts channel i counter; reads 0 |
| 0x02 | CHON | bit i enables channel i |
| 0x03 | BSEL | bit i selects base timer 1 (1) or base timer 0 (0) for channel i |
| 0x04 | IRQEN | bit i enables the interrupt of channel i |
| 0x05 | TFLAG | bit i is the time-out flag of channel i; write 1 clears |
| 0x06 / 0x07 | BLD0 / BLD1 | 8-bit reload value of base timer 0 / 1 |
| 0x10 + 2i / 0x11 + 2i | CLDi | low / high byte of channel i reload value |

## Requirements
- R1: After reset, every register reads 0x00 and all `irq_o` bits are 0.
- R2: In CTRL, bits 7, 6 and 5 read back as written. Bits 4:2 and bits 1:0 always read 0. CHRST always reads 0.
- R3: A base timer is loaded with M and a channel is loaded with C. After the CTRL write that sets the run enable, the channel's TFLAG bit first becomes 1 exactly (M+1)*(C+1) clock edges later. The base timer is the one chosen by the channel's BSEL bit.
- R4: After a time-out the channel reloads and keeps running. The next time-out follows (M+1)*(C+1) edges after the previous one.
- R5: Writing 1 to a TFLAG bit clears it, and writing 0 leaves it unchanged. A time-out in the same cycle as a clear leaves the flag set.
- R6: `irq_o[i]` is 1 exactly when TFLAG bit i and IRQEN bit i are both 1.
- R7: Writing 0 to the run enable clears all TFLAG bits in the same edge. No time-out occurs while the enable stays 0.
- R8: While CTRL[6] is 1 and `wait_i` is 1, all counting halts and resumes where it stopped. With CTRL[6] at 0, `wait_i` has no effect.
- R9: While CTRL[5] is 1 and `freeze_i` is 1, all counters hold and no time-out is produced. With CTRL[5] at 0, `freeze_i` has no effect.
- R10: Writing 1 to CTRL[j] while enabled reloads base timer j, when at least one enabled channel selects it. This shifts the timing of every channel on base j and of no channel on the other base.
- R11: Writing 1 to CHRST bit i reloads channel i's counter from its load value, when the module and channel i are both enabled.
- R12: A CHRST bit aimed at a disabled channel has no effect, and force-load bits written while the module is disabled have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_sel_i | input | 1 | Register access select |
| bus_wr_i | input | 1 | Write strobe, one cycle per write |
| bus_addr_i | input | 5 | Register byte offset |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, combinational from address |
| wait_i | input | 1 | Wait state indication |
| freeze_i | input | 1 | Debug halt indication |
| irq_o | output | 8 | Per-channel interrupt requests |

## Verification
The hardest behaviour to reach from the ports is a base-timer force-load that lands partway through a prescale interval. Its effect is only visible as a later time-out on one channel and an unchanged time-out on a neighbour using the other base. The bench starts two channels with identical settings on different bases and issues the force write a fixed number of edges after enable. It then records the time-out cycle of each channel separately. Wait and freeze stalls are handled the same way: the input is held for a known number of edges, and the bench expects the time-out delayed by exactly that amount, or not delayed when the matching control bit is clear.

// File: rtl/ptimer_pkg.sv
package ptimer_pkg;
    // register byte offsets
    localparam int ADR_CTRL  = 0;
    localparam int ADR_CHRST = 1;
    localparam int ADR_CHON  = 2;
    localparam int ADR_BSEL  = 3;
    localparam int ADR_IRQEN = 4;
    localparam int ADR_TFLAG = 5;
    localparam int ADR_BLD   = 6;
    localparam int ADR_CLD   = 16;

    // control byte fields
    localparam int CTRL_RUN    = 7;
    localparam int CTRL_WSTOP  = 6;
    localparam int CTRL_FSTALL = 5;

    // base timers are picked by one select bit per channel
    localparam int NUM_BASE = 2;
    localparam int BUS_W    = 8;
endpackage

// File: rtl/ptimer_base.sv
module ptimer_base #(
    parameter int BASE_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              run_i,
    input  logic              start_i,
    input  logic              force_i,
    input  logic [BASE_W-1:0] load_i,
    output logic              tick_o
);
    typedef struct packed {
        logic [BASE_W-1:0] cnt;
    } base_st_t;

    base_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (start_i || force_i) begin
            st_d.cnt = load_i;
        end else if (run_i) begin
            st_d.cnt = (st_q.cnt == '0) ? load_i : st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign tick_o = run_i && (st_q.cnt == '0);

    AST_BASE_HOLD_WHEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!run_i && !start_i && !force_i) |=> $stable(st_q.cnt)); // R8

    AST_BASE_FORCE_RELOADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        force_i |=> (st_q.cnt == $past(load_i))); // R10
endmodule

// File: rtl/ptimer_chan.sv
module ptimer_chan #(
    parameter int CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic             tick_i,
    input  logic             start_i,
    input  logic             force_i,
    input  logic [CNT_W-1:0] load_i,
    output logic             expire_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } chan_st_t;

    chan_st_t st_d, st_q;
    logic     step;

    assign step = en_i && tick_i;

    always_comb begin
        st_d = st_q;
        if (start_i || force_i) begin
            st_d.cnt = load_i;
        end else if (step) begin
            st_d.cnt = (st_q.cnt == '0) ? load_i : st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign expire_o = step && (st_q.cnt == '0);

    AST_CHAN_HOLD_NO_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!step && !start_i && !force_i) |=> $stable(st_q.cnt)); // R9

    AST_CHAN_RELOAD_AFTER_EXPIRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (expire_o && !start_i && !force_i) |=> (st_q.cnt == $past(load_i))); // R4

    AST_CHAN_FORCE_RELOADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        force_i |=> (st_q.cnt == $past(load_i))); // R11
endmodule

// File: rtl/ptimer_regs.sv
module ptimer_regs
    import ptimer_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int BASE_W = 8,
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 5
) (
    input  logic                           clk_i,
    input  logic                           rst_ni,
    input  logic                           bus_sel_i,
    input  logic                           bus_wr_i,
    input  logic [ADDR_W-1:0]              bus_addr_i,
    input  logic [BUS_W-1:0]               bus_wdata_i,
    output logic [BUS_W-1:0]               bus_rdata_o,
    input  logic                           wait_i,
    input  logic                           freeze_i,
    input  logic [NUM_CH-1:0]              expire_i,
    output logic                           run_o,
    output logic                           stall_o,
    output logic [NUM_CH-1:0]              chon_o,
    output logic [NUM_CH-1:0]              bsel_o,
    output logic [NUM_CH-1:0]              irqen_o,
    output logic [NUM_CH-1:0]              flag_o,
    output logic [NUM_BASE-1:0][BASE_W-1:0] bld_o,
    output logic [NUM_CH-1:0][CNT_W-1:0]   cld_o,
    output logic                           start_o,
    output logic [NUM_CH-1:0]              chstart_o,
    output logic [NUM_BASE-1:0]            bforce_o,
    output logic [NUM_CH-1:0]              cforce_o
);
    localparam int LD_BYTES = CNT_W / BUS_W;

    typedef struct packed {
        logic                            run;
        logic                            wstop;
        logic                            fstall;
        logic [NUM_CH-1:0]               chon;
        logic [NUM_CH-1:0]               bsel;
        logic [NUM_CH-1:0]               irqen;
        logic [NUM_CH-1:0]               flag;
        logic [NUM_BASE-1:0][BASE_W-1:0] bld;
        logic [NUM_CH-1:0][CNT_W-1:0]    cld;
    } reg_st_t;

    reg_st_t           st_d, st_q;
    logic              wr;
    logic [NUM_CH-1:0] clr;
    int                adr;

    assign wr  = bus_sel_i && bus_wr_i;
    assign adr = int'(bus_addr_i);

    always_comb begin
        st_d      = st_q;
        clr       = '0;
        start_o   = 1'b0;
        chstart_o = '0;
        bforce_o  = '0;
        cforce_o  = '0;
        if (wr) begin
            if (adr == ADR_CTRL) begin
                st_d.run    = bus_wdata_i[CTRL_RUN];
                st_d.wstop  = bus_wdata_i[CTRL_WSTOP];
                st_d.fstall = bus_wdata_i[CTRL_FSTALL];
                start_o     = bus_wdata_i[CTRL_RUN] && !st_q.run;
                bforce_o    = st_q.run ? bus_wdata_i[NUM_BASE-1:0] : '0;
            end
            if (adr == ADR_CHRST) begin
                cforce_o = bus_wdata_i[NUM_CH-1:0] & st_q.chon & {NUM_CH{st_q.run}};
            end
            if (adr == ADR_CHON) begin
                st_d.chon = bus_wdata_i[NUM_CH-1:0];
                chstart_o = bus_wdata_i[NUM_CH-1:0] & ~st_q.chon;
            end
            if (adr == ADR_BSEL)  st_d.bsel  = bus_wdata_i[NUM_CH-1:0];
            if (adr == ADR_IRQEN) st_d.irqen = bus_wdata_i[NUM_CH-1:0];
            if (adr == ADR_TFLAG) clr        = bus_wdata_i[NUM_CH-1:0];
            for (int j = 0; j < NUM_BASE; j++) begin
                if (adr == ADR_BLD + j) st_d.bld[j] = bus_wdata_i[BASE_W-1:0];
            end
            for (int i = 0; i < NUM_CH; i++) begin
                for (int b = 0; b < LD_BYTES; b++) begin
                    if (adr == ADR_CLD + i * LD_BYTES + b) begin
                        st_d.cld[i][b*BUS_W +: BUS_W] = bus_wdata_i;
                    end
                end
            end
        end
        // a time-out in the clearing cycle wins; disabling clears in the same edge
        st_d.flag = st_d.run ? ((st_q.flag & ~clr) | expire_i) : '0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    always_comb begin
        bus_rdata_o = '0;
        if (adr == ADR_CTRL) begin
            bus_rdata_o[CTRL_RUN]    = st_q.run;
            bus_rdata_o[CTRL_WSTOP]  = st_q.wstop;
            bus_rdata_o[CTRL_FSTALL] = st_q.fstall;
        end
        if (adr == ADR_CHON)  bus_rdata_o[NUM_CH-1:0] = st_q.chon;
        if (adr == ADR_BSEL)  bus_rdata_o[NUM_CH-1:0] = st_q.bsel;
        if (adr == ADR_IRQEN) bus_rdata_o[NUM_CH-1:0] = st_q.irqen;
        if (adr == ADR_TFLAG) bus_rdata_o[NUM_CH-1:0] = st_q.flag;
        for (int j = 0; j < NUM_BASE; j++) begin
            if (adr == ADR_BLD + j) bus_rdata_o[BASE_W-1:0] = st_q.bld[j];
        end
        for (int i = 0; i < NUM_CH; i++) begin
            for (int b = 0; b < LD_BYTES; b++) begin
                if (adr == ADR_CLD + i * LD_BYTES + b) begin
                    bus_rdata_o = st_q.cld[i][b*BUS_W +: BUS_W];
                end
            end
        end
    end

    assign run_o   = st_q.run;
    assign stall_o = (wait_i && st_q.wstop) || (freeze_i && st_q.fstall);
    assign chon_o  = st_q.chon;
    assign bsel_o  = st_q.bsel;
    assign irqen_o = st_q.irqen;
    assign flag_o  = st_q.flag;
    assign bld_o   = st_q.bld;
    assign cld_o   = st_q.cld;

    AST_FLAGS_CLEAR_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !st_q.run |-> (st_q.flag == '0)); // R7

    AST_FLAG_W1C: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr && adr == ADR_TFLAG) |=>
            ((st_q.flag & $past(bus_wdata_i[NUM_CH-1:0]) & ~$past(expire_i)) == '0)); // R5

    AST_FORCE_NEEDS_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((bforce_o != '0) || (cforce_o != '0)) |-> st_q.run); // R12
endmodule

// File: rtl/ptimer_top.sv
module ptimer_top
    import ptimer_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int BASE_W = 8,
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 5
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              bus_sel_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [BUS_W-1:0]  bus_wdata_i,
    output logic [BUS_W-1:0]  bus_rdata_o,
    input  logic              wait_i,
    input  logic              freeze_i,
    output logic [NUM_CH-1:0] irq_o
);
    logic                            run;
    logic                            stall;
    logic [NUM_CH-1:0]               chon, bsel, irqen, flag;
    logic [NUM_BASE-1:0][BASE_W-1:0] bld;
    logic [NUM_CH-1:0][CNT_W-1:0]    cld;
    logic                            start;
    logic [NUM_CH-1:0]               chstart, cforce, expire, ctick;
    logic [NUM_BASE-1:0]             bforce, btick, bactive;

    ptimer_regs #(
        .NUM_CH (NUM_CH),
        .BASE_W (BASE_W),
        .CNT_W  (CNT_W),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .bus_sel_i   (bus_sel_i),
        .bus_wr_i    (bus_wr_i),
        .bus_addr_i  (bus_addr_i),
        .bus_wdata_i (bus_wdata_i),
        .bus_rdata_o (bus_rdata_o),
        .wait_i      (wait_i),
        .freeze_i    (freeze_i),
        .expire_i    (expire),
        .run_o       (run),
        .stall_o     (stall),
        .chon_o      (chon),
        .bsel_o      (bsel),
        .irqen_o     (irqen),
        .flag_o      (flag),
        .bld_o       (bld),
        .cld_o       (cld),
        .start_o     (start),
        .chstart_o   (chstart),
        .bforce_o    (bforce),
        .cforce_o    (cforce)
    );

    for (genvar j = 0; j < NUM_BASE; j++) begin : g_base
        logic [NUM_CH-1:0] users;
        assign users      = chon & ((j == 0) ? ~bsel : bsel);
        assign bactive[j] = run && (users != '0);

        ptimer_base #(.BASE_W(BASE_W)) u_base (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .run_i   (bactive[j] && !stall),
            .start_i (start),
            .force_i (bforce[j] && bactive[j]),
            .load_i  (bld[j]),
            .tick_o  (btick[j])
        );
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
        assign ctick[i] = btick[bsel[i]];

        ptimer_chan #(.CNT_W(CNT_W)) u_chan (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .en_i     (run && chon[i]),
            .tick_i   (ctick[i]),
            .start_i  (start || chstart[i]),
            .force_i  (cforce[i]),
            .load_i   (cld[i]),
            .expire_o (expire[i])
        );
    end

    assign irq_o = flag & irqen;

    AST_NO_TICK_WHILE_STALLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stall |-> (btick == '0)); // R9

    AST_NO_EXPIRE_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !run |-> (expire == '0)); // R7
endmodule

// File: tb/ptimer_top_tb_top.sv
module ptimer_top_tb_top;
    localparam int A_CTRL = 0, A_CHRST = 1, A_CHON = 2, A_BSEL = 3;
    localparam int A_IRQEN = 4, A_TFLAG = 5, A_BLD = 6, A_CLD = 16;
    localparam int NVEC = 6;
    // {base load[31:24], channel load[23:8], channel[7:4], base select[3:0]}
    localparam logic [31:0] VEC [NVEC] = '{
        32'h01000200, 32'h00000031, 32'h04000171,
        32'h02000550, 32'h07000321, 32'h00000960
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel = 1'b0, wr = 1'b0;
    logic [4:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       wait_s = 1'b0, frz_s = 1'b0;
    logic [7:0] irq;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    ptimer_top dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .bus_sel_i   (sel),
        .bus_wr_i    (wr),
        .bus_addr_i  (addr),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .wait_i      (wait_s),
        .freeze_i    (frz_s),
        .irq_o       (irq)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wreg(input int a, input int d);
        sel = 1'b1; wr = 1'b1; addr = 5'(a); wdata = 8'(d);
        @(negedge clk);
        sel = 1'b0; wr = 1'b0;
    endtask

    task automatic rreg(input int a, output int d);
        addr = 5'(a);
        #1;
        d = int'(rdata);
    endtask

    task automatic edges(input int k);
        repeat (k) @(negedge clk);
    endtask

    // edges after the current point until irq[ch] is seen
    task automatic until_irq(input int ch, input int start, output int n);
        n = start;
        while (!irq[ch] && n < 5000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic setup(input int ch, input int bs, input int m, input int c, input int ctrl);
        wreg(A_CTRL, 0);
        wreg(A_BLD + bs, m);
        wreg(A_CLD + 2 * ch, c & 8'hFF);
        wreg(A_CLD + 2 * ch + 1, (c >> 8) & 8'hFF);
        wreg(A_BSEL, bs << ch);
        wreg(A_IRQEN, 8'hFF);
        wreg(A_CHON, 1 << ch);
        wreg(A_CTRL, ctrl);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int v, n, t0, t1;
        edges(3);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset values
        for (int a = 0; a < 32; a++) begin
            rreg(a, v);
            check("R1 reg", v, 0);
        end
        check("R1 irq", int'(irq), 0);

        // R2: control layout and readback
        wreg(A_CTRL, 8'hFF);
        rreg(A_CTRL, v);
        check("R2 ctrl readback", v, 8'hE0);
        wreg(A_CHRST, 8'hFF);
        rreg(A_CHRST, v);
        check("R2 chrst reads zero", v, 0);
        wreg(A_CTRL, 0);

        // R3 and R4: table of loads, channels and bases
        for (int k = 0; k < NVEC; k++) begin
            int m, c, ch, bs, p;
            m  = int'(VEC[k][31:24]);
            c  = int'(VEC[k][23:8]);
            ch = int'(VEC[k][7:4]);
            bs = int'(VEC[k][3:0]);
            p  = (m + 1) * (c + 1);
            setup(ch, bs, m, c, 8'h80);
            until_irq(ch, 0, n);
            check("R3 first period", n, p);
            wreg(A_TFLAG, 1 << ch);
            until_irq(ch, 0, n);
            check("R4 next period", n, p - 1);
        end

        // R6 and R5: masking and clearing, long period (100 edges)
        setup(1, 0, 9, 9, 8'h80);
        wreg(A_IRQEN, 0);
        edges(110);
        rreg(A_TFLAG, v);
        check("R6 flag set", v, 2);
        check("R6 irq masked", int'(irq), 0);
        wreg(A_IRQEN, 2);
        check("R6 irq unmasked", int'(irq), 2);
        wreg(A_TFLAG, 0);
        rreg(A_TFLAG, v);
        check("R5 write zero keeps", v, 2);
        wreg(A_TFLAG, 2);
        rreg(A_TFLAG, v);
        check("R5 write one clears", v, 0);

        // R5: clear in the same edge as a time-out (period 1)
        setup(0, 0, 0, 0, 8'h80);
        edges(2);
        wreg(A_TFLAG, 1);
        rreg(A_TFLAG, v);
        check("R5 set wins", v & 1, 1);

        // R7: disabling clears flags and stops time-outs
        wreg(A_CTRL, 0);
        rreg(A_TFLAG, v);
        check("R7 flags cleared", v, 0);
        edges(50);
        rreg(A_TFLAG, v);
        check("R7 no timeout when off", v, 0);
        check("R7 irq low", int'(irq), 0);

        // R8: wait stop, period 6, 5 stalled edges
        setup(0, 0, 1, 2, 8'hC0);
        wait_s = 1'b1; edges(5); wait_s = 1'b0;
        until_irq(0, 5, n);
        check("R8 wait stalls", n, 11);
        setup(0, 0, 1, 2, 8'h80);
        wait_s = 1'b1; edges(5); wait_s = 1'b0;
        until_irq(0, 5, n);
        check("R8 wait ignored", n, 6);

        // R9: freeze stall
        setup(0, 0, 1, 2, 8'hA0);
        frz_s = 1'b1; edges(5); frz_s = 1'b0;
        until_irq(0, 5, n);
        check("R9 freeze stalls", n, 11);
        setup(0, 0, 1, 2, 8'hA0);
        wait_s = 1'b1; edges(5); wait_s = 1'b0;
        until_irq(0, 5, n);
        check("R9 wait without stop bit", n, 6);
        setup(0, 0, 1, 2, 8'h80);
        frz_s = 1'b1; edges(5); frz_s = 1'b0;
        until_irq(0, 5, n);
        check("R9 freeze ignored", n, 6);

        // R10: force base 0 at edge 3; ch0 on base 0, ch1 on base 1
        wreg(A_CTRL, 0);
        wreg(A_BLD, 3);
        wreg(A_BLD + 1, 3);
        wreg(A_CLD, 0);
        wreg(A_CLD + 1, 0);
        wreg(A_CLD + 2, 0);
        wreg(A_CLD + 3, 0);
        wreg(A_BSEL, 2);
        wreg(A_IRQEN, 8'hFF);
        wreg(A_CHON, 3);
        wreg(A_CTRL, 8'h80);
        edges(2);
        wreg(A_CTRL, 8'h81);
        t0 = -1; t1 = -1;
        for (int e = 3; e < 40; e++) begin
            if (irq[0] && t0 < 0) t0 = e;
            if (irq[1] && t1 < 0) t1 = e;
            @(negedge clk);
        end
        check("R10 forced base delays its channel", t0, 7);
        check("R10 other base untouched", t1, 4);

        // R11: channel restart at edge 3, base load 0, channel load 3
        setup(0, 0, 0, 3, 8'h80);
        edges(2);
        wreg(A_CHRST, 1);
        until_irq(0, 3, n);
        check("R11 channel restart", n, 7);

        // R12: restart aimed at a disabled channel, and force bits while off
        setup(0, 0, 0, 3, 8'h80);
        edges(2);
        wreg(A_CHRST, 2);
        until_irq(0, 3, n);
        check("R12 restart of disabled channel ignored", n, 4);
        wreg(A_CTRL, 0);
        wreg(A_CTRL, 8'h03);
        rreg(A_CTRL, v);
        check("R12 force while off", v, 0);
        edges(20);
        check("R12 no irq while off", int'(irq), 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule